// File: doc/BRIEF.md
# In-order issue hazard checker

This block sits between instruction decode and the functional units of an in-order pipeline. Each cycle it looks at the one decoded instruction waiting at the head of decode and decides whether that instruction may leave for its functional unit in this cycle. It combines the readiness of the target unit, a per-register "pending writer" vector from the scoreboard, a per-register "result can be forwarded" vector, a scoreboard-full indication and its own record of an unresolved branch.

When every condition holds, the block raises exactly one bit of a one-hot issue vector, selecting the target unit, and decode advances. Otherwise it holds decode with a stall that is formed combinationally from the inputs of the same cycle. The only state is a single flag that remembers a branch is in flight. It is set when a branch issues and cleared by a resolve pulse from the branch unit.

Top module: `issue_gate`

## Requirements
- R1: At most one instruction issues per cycle. `unit_issue` is zero or one-hot, and bit k rises only when `dec_valid` is 1 and `dec_unit` equals k.
- R2: An instruction issues only if bit `dec_unit` of `unit_free_now` or of `unit_free_next` is 1. A `dec_unit` value at or above NUM_UNITS never issues.
- R3: For each source whose use flag is 1 and whose index is nonzero, issue requires that source's bit of `reg_pending` to be 0 or its bit of `reg_fwd_ok` to be 1. An unused source imposes no condition.
- R4: When `dec_rd_we` is 1 and `dec_rd` is nonzero, the instruction stalls if bit `dec_rd` of `reg_pending` is 1. This ensures each register has at most one pending writer. When `dec_rd_we` is 0, the destination imposes no condition.
- R5: Register index 0 never causes a stall, as destination or as source, whatever bit 0 of `reg_pending` holds.
- R6: An instruction with `dec_branch` set does not issue while `branch_busy` is 1. Non-branch instructions are unaffected by `branch_busy`.
- R7: `branch_busy` is 0 after reset. It becomes 1 in the cycle after a branch issues. It becomes 0 in the cycle after a `branch_done` pulse, provided no branch issues in the same cycle.
- R8: While `sb_full` is 1, nothing issues.
- R9: `dec_stall` equals `dec_valid` AND NOT issue, combinationally in the same cycle as the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decoded instruction present |
| dec_unit | input | UNIT_W | Index of the target functional unit |
| dec_rs1 | input | RIDX_W | First source register index |
| dec_rs1_used | input | 1 | First source is read |
| dec_rs2 | input | RIDX_W | Second source register index |
| dec_rs2_used | input | 1 | Second source is read |
| dec_rd | input | RIDX_W | Destination register index |
| dec_rd_we | input | 1 | Instruction writes its destination |
| dec_branch | input | 1 | Instruction is a branch |
| unit_free_now | input | NUM_UNITS | Unit can accept this cycle |
| unit_free_next | input | NUM_UNITS | Unit will be free next cycle |
| reg_pending | input | NUM_REGS | Register has an issued, unretired writer |
| reg_fwd_ok | input | NUM_REGS | Pending result is available for forwarding |
| sb_full | input | 1 | Scoreboard has no free slot |
| branch_done | input | 1 | Outstanding branch resolved (pulse) |
| unit_issue | output | NUM_UNITS | One-hot issue strobe to the selected unit |
| dec_stall | output | 1 | Hold decode this cycle |
| branch_busy | output | 1 | An unresolved branch is in flight |

## Verification
The assertions assume that `branch_done` only pulses while a branch is actually outstanding. They also assume that all inputs are settled before each rising edge. The bench meets both conditions. It changes every input on the falling edge and issues a resolve pulse only inside branch sequences. Those sequences exercise the flag set, the blocking of a second branch, and the clearing of the flag.

// File: rtl/issue_pkg.sv
package issue_pkg;

  // Reasons an instruction may be held; internal to the block.
  typedef struct packed {
    logic unit_busy;
    logic src_wait;
    logic dst_conflict;
    logic branch_block;
    logic sb_full;
  } hold_t;

  localparam int unsigned NUM_SRC = 2;

endpackage

// File: rtl/src_check.sv
module src_check #(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned RIDX_W = $clog2(NUM_REGS)
) (
  input  logic [RIDX_W-1:0]   idx,
  input  logic                used,
  input  logic [NUM_REGS-1:0] pending,
  input  logic [NUM_REGS-1:0] fwd_ok,
  output logic                ready
);
  logic zero_reg;
  assign zero_reg = (idx == '0);
  // Operand comes from the register file when no writer is pending,
  // or from the forwarding path when the pending result exists.
  always_comb begin
    ready = 1'b1;
    if (used && !zero_reg)
      ready = !pending[idx] || fwd_ok[idx];
  end
endmodule

// File: rtl/unit_select.sv
module unit_select #(
  parameter int unsigned NUM_UNITS = 4,
  localparam int unsigned UNIT_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic [UNIT_W-1:0]    unit,
  input  logic [NUM_UNITS-1:0] free_now,
  input  logic [NUM_UNITS-1:0] free_next,
  input  logic                 go,
  output logic                 unit_ok,
  output logic [NUM_UNITS-1:0] strobe
);
  logic [NUM_UNITS-1:0] hit;
  for (genvar k = 0; k < NUM_UNITS; k++) begin : g_unit
    assign hit[k]    = (unit == UNIT_W'(k));
    assign strobe[k] = go && hit[k];
  end
  assign unit_ok = |(hit & (free_now | free_next));
endmodule

// File: rtl/branch_track.sv
module branch_track (
  input  logic clk,
  input  logic rst,
  input  logic branch_issue,
  input  logic resolve,
  output logic busy
);
  always_ff @(posedge clk) begin
    if (rst)               busy <= 1'b0;
    else if (branch_issue) busy <= 1'b1;
    else if (resolve)      busy <= 1'b0;
  end
endmodule

// File: rtl/issue_gate.sv
module issue_gate
  import issue_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 32,
  parameter int unsigned NUM_UNITS = 4,
  localparam int unsigned RIDX_W = $clog2(NUM_REGS),
  localparam int unsigned UNIT_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 dec_valid,
  input  logic [UNIT_W-1:0]    dec_unit,
  input  logic [RIDX_W-1:0]    dec_rs1,
  input  logic                 dec_rs1_used,
  input  logic [RIDX_W-1:0]    dec_rs2,
  input  logic                 dec_rs2_used,
  input  logic [RIDX_W-1:0]    dec_rd,
  input  logic                 dec_rd_we,
  input  logic                 dec_branch,
  input  logic [NUM_UNITS-1:0] unit_free_now,
  input  logic [NUM_UNITS-1:0] unit_free_next,
  input  logic [NUM_REGS-1:0]  reg_pending,
  input  logic [NUM_REGS-1:0]  reg_fwd_ok,
  input  logic                 sb_full,
  input  logic                 branch_done,
  output logic [NUM_UNITS-1:0] unit_issue,
  output logic                 dec_stall,
  output logic                 branch_busy
);

  logic [RIDX_W-1:0]  src_idx  [NUM_SRC];
  logic [NUM_SRC-1:0] src_used;
  logic [NUM_SRC-1:0] src_rdy;
  hold_t              hold;
  logic               unit_ok;
  logic               go;

  assign src_idx[0] = dec_rs1;
  assign src_idx[1] = dec_rs2;
  assign src_used   = {dec_rs2_used, dec_rs1_used};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    src_check #(.NUM_REGS(NUM_REGS)) u_src (
      .idx     (src_idx[s]),
      .used    (src_used[s]),
      .pending (reg_pending),
      .fwd_ok  (reg_fwd_ok),
      .ready   (src_rdy[s])
    );
  end

  unit_select #(.NUM_UNITS(NUM_UNITS)) u_unit (
    .unit      (dec_unit),
    .free_now  (unit_free_now),
    .free_next (unit_free_next),
    .go        (go),
    .unit_ok   (unit_ok),
    .strobe    (unit_issue)
  );

  always_comb begin
    hold.unit_busy    = !unit_ok;
    hold.src_wait     = !(&src_rdy);
    hold.dst_conflict = dec_rd_we && (dec_rd != '0) && reg_pending[dec_rd];
    hold.branch_block = dec_branch && branch_busy;
    hold.sb_full      = sb_full;
  end

  assign go        = dec_valid && (hold == '0);
  assign dec_stall = dec_valid && !go;

  branch_track u_br (
    .clk          (clk),
    .rst          (rst),
    .branch_issue (go && dec_branch),
    .resolve      (branch_done),
    .busy         (branch_busy)
  );

  logic any_issue;
  assign any_issue = |unit_issue;

  // R1: single issue, only with a valid instruction
  a_r1_one_issue: assert property (@(posedge clk) disable iff (rst)
    $onehot0(unit_issue) && (any_issue -> dec_valid));
  // R2: target unit must be free now or next cycle
  a_r2_unit_free: assert property (@(posedge clk) disable iff (rst)
    any_issue |-> |(unit_issue & (unit_free_now | unit_free_next)));
  // R4: no second pending writer to a nonzero register
  a_r4_no_waw: assert property (@(posedge clk) disable iff (rst)
    (any_issue && dec_rd_we && dec_rd != '0) |-> !reg_pending[dec_rd]);
  // R6: one unresolved branch at a time
  a_r6_one_branch: assert property (@(posedge clk) disable iff (rst)
    (any_issue && dec_branch) |-> !branch_busy);
  // R7: flag set after branch issue
  a_r7_flag_set: assert property (@(posedge clk) disable iff (rst)
    (any_issue && dec_branch) |=> branch_busy);
  // R7: flag cleared after resolve
  a_r7_flag_clear: assert property (@(posedge clk) disable iff (rst)
    (branch_done && !(any_issue && dec_branch)) |=> !branch_busy);
  // R8: full scoreboard blocks issue
  a_r8_full_blocks: assert property (@(posedge clk) disable iff (rst)
    sb_full |-> !any_issue);
  // R9: stall is the complement of issue for a valid instruction
  a_r9_stall_xor: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (dec_stall != any_issue));

endmodule

// File: tb/issue_gate_tb_top.sv
module issue_gate_tb_top;
  localparam int NR = 32;
  localparam int NU = 4;

  logic clk = 0, rst = 1;
  logic dv, u1, u2, we, br, full, done;
  logic [1:0] fu;
  logic [4:0] rs1, rs2, rd;
  logic [NU-1:0] fnow, fnxt;
  logic [NR-1:0] pend, fwd;
  logic [NU-1:0] iv;
  logic stall, bbusy;

  int checks = 0, fails = 0;
  bit bp_m = 0;

  always #5 clk = ~clk;

  issue_gate #(.NUM_REGS(NR), .NUM_UNITS(NU)) dut_i (
    .clk(clk), .rst(rst), .dec_valid(dv), .dec_unit(fu),
    .dec_rs1(rs1), .dec_rs1_used(u1), .dec_rs2(rs2), .dec_rs2_used(u2),
    .dec_rd(rd), .dec_rd_we(we), .dec_branch(br),
    .unit_free_now(fnow), .unit_free_next(fnxt),
    .reg_pending(pend), .reg_fwd_ok(fwd), .sb_full(full),
    .branch_done(done), .unit_issue(iv), .dec_stall(stall),
    .branch_busy(bbusy));

  function automatic bit src_ok(logic [4:0] r, logic use_it);
    return !use_it || r == 0 || !pend[r] || fwd[r];
  endfunction

  function automatic bit exp_go();
    if (!dv) return 0;
    if (!(fnow[fu] || fnxt[fu])) return 0;
    if (!src_ok(rs1, u1) || !src_ok(rs2, u2)) return 0;
    if (we && rd != 0 && pend[rd]) return 0;
    if (br && bp_m) return 0;
    if (full) return 0;
    return 1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    dv = 0; fu = 0; rs1 = 0; rs2 = 0; rd = 0; u1 = 0; u2 = 0; we = 0;
    br = 0; full = 0; done = 0; fnow = '1; fnxt = '0; pend = '0; fwd = '0;
  endtask

  // Inputs set at negedge by caller; compare combinational outputs,
  // advance one clock, then compare the branch flag.
  task automatic step(string tag);
    bit g;
    #1;
    g = exp_go();
    chk(tag, iv, g ? (1 << fu) : 0);
    chk({tag, "/R9"}, stall, dv && !g);
    @(posedge clk);
    if (g && br) bp_m = 1;
    else if (done) bp_m = 0;
    @(negedge clk);
    chk({tag, "/R7"}, bbusy, bp_m);
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    chk("R7 reset", bbusy, 0);
    rst = 0;
    step("R9 idle");

    // R1/R2: unit index against all free-now / free-next patterns
    for (int f = 0; f < NU; f++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          idle(); dv = 1; fu = f[1:0]; fnow = a[3:0]; fnxt = b[3:0];
          step("R2");
        end

    // R4/R5: destination versus pending bit, with and without write
    for (int d = 0; d < NR; d++)
      for (int c = 0; c < NR; c++)
        for (int w = 0; w < 2; w++) begin
          idle(); dv = 1; fu = 2'(d % NU); rd = d[4:0]; we = w[0];
          pend = NR'(1) << c;
          step(d == 0 ? "R5 dst" : "R4");
        end

    // R3/R5: each source versus pending and forward bits
    for (int s = 0; s < 2; s++)
      for (int r = 0; r < NR; r++)
        for (int c = 0; c < NR; c += 3)
          for (int m = 0; m < 4; m++) begin
            idle(); dv = 1; fu = 1;
            pend = NR'(1) << ((c == 0) ? r : c);
            fwd  = m[1] ? pend : '0;
            if (s == 0) begin rs1 = r[4:0]; u1 = m[0]; rs2 = 5'(r + 1); u2 = 1; end
            else        begin rs2 = r[4:0]; u2 = m[0]; rs1 = 5'(r + 1); u1 = 1; end
            step(r == 0 ? "R5 src" : "R3");
          end

    // R8: full blocks otherwise clean instructions
    for (int f = 0; f < NU; f++)
      for (int k = 0; k < 2; k++) begin
        idle(); dv = 1; fu = f[1:0]; full = k[0];
        step("R8");
      end

    // R6/R7: branch sequences
    idle(); dv = 1; br = 1; fu = 3; step("R7 set");
    idle(); dv = 1; br = 1; fu = 3; step("R6 second branch");
    idle(); dv = 1; fu = 0; step("R6 nonbranch");
    idle(); dv = 1; br = 1; fu = 3; done = 1; step("R6 resolve same cycle");
    idle(); step("R7 cleared");
    idle(); dv = 1; br = 1; fu = 3; full = 1; step("R7 blocked branch no set");
    idle(); dv = 1; br = 1; fu = 3; step("R7 set again");
    idle(); done = 1; step("R7 clear");
    idle(); dv = 1; br = 1; fu = 2; fnow = '0; step("R2 branch unit busy");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule